// File: doc/BRIEF.md
# Skewed Eight-Bank FFT Address Generator

This block sequences the memory addresses for an in-place 64-point FFT computed as two radix-8 passes of eight octets each. The 64 complex samples are spread over eight dual-port banks of eight words. Sample `8*r + j` lives at word `r` of bank `(j + r) mod 8`, so bank 0 holds samples 0, 15, 22, 29, ... and bank 1 holds 1, 8, 23, 30, .... Because of this diagonal skew, the eight samples of any octet used by either pass fall into eight different banks. Each octet is therefore fetched in a single cycle, and each sample is read and written back only twice per transform.

For every read cycle the block drives one 3-bit word address per bank and a rotation amount. The rotation tells the data crossbar that logical lane `k` sits in physical bank `(k + rot) mod 8`. It also reports the current pass and octet. Write enables and write addresses are the read values delayed by the datapath latency `PIPE_LAT`, because results return in place. A drain gap of `PIPE_LAT` cycles separates the passes. This gap ensures that the second pass reads only data the first pass has finished writing, and that no word is read and written in the same cycle. The results stay in bit-reversed order, and a later stage reorders them.

The control is a five-state machine. IDLE waits for `start`. RUN_A issues the eight first-pass octets. DRAIN waits out the pipeline. RUN_B issues the eight second-pass octets. FLUSH waits for the last writes and then returns to IDLE. The transitions are:
- IDLE to RUN_A when `start` is high.
- RUN_A to DRAIN after octet 7.
- DRAIN to RUN_B after `PIPE_LAT` cycles.
- RUN_B to FLUSH after octet 7.
- FLUSH to IDLE after `PIPE_LAT` cycles.

Top module: `skew_bank_agu`

## Requirements
- R1: After reset, and in IDLE, `busy`, `done`, `rd_en` and `wr_en` are 0, and `pass_idx`, `octet_idx`, `rd_rot`, every `rd_addr` field and every `wr_addr` field are 0. Bank `b` occupies bits `[3b+2:3b]` of `rd_addr` and `wr_addr`.
- R2: A high `start` sampled in IDLE puts the block in RUN_A with octet 0 on the next cycle. `start` has no effect while `busy` is high.
- R3: In RUN_A, the octet counter `n` steps 0 to 7 on consecutive cycles with `pass_idx`=0. Lane `k` reads sample `n + 8k`, so bank `b` gets address `(b - n) mod 8`, and `rd_rot` = `n`.
- R4: In RUN_B, the octet counter `r` steps 0 to 7 with `pass_idx`=1. Lane `k` reads sample `8r + k`, so every bank gets address `r`, and `rd_rot` = `r`.
- R5: DRAIN lasts exactly `PIPE_LAT` cycles between the last RUN_A read and the first RUN_B read. During DRAIN, `rd_en`=0, `pass_idx`=1 and `octet_idx`=0.
- R6: In every cycle, `wr_en` and `wr_addr` equal the `rd_en` and `rd_addr` values from exactly `PIPE_LAT` cycles earlier.
- R7: No bank is read and written at the same word address in the same cycle.
- R8: Within each pass, every read cycle touches eight distinct samples, one per bank. Over a transform, each of the 64 samples is read exactly once in each pass.
- R9: `done` is high for exactly one cycle, the last FLUSH cycle, which is the cycle of the final write. `busy` is low on the following cycle.
- R10: `busy` is high in RUN_A, DRAIN, RUN_B and FLUSH. `octet_idx` is 0 outside the two run states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transform (sampled in IDLE) |
| busy | output | 1 | Transform in progress |
| done | output | 1 | One-cycle pulse on the final write cycle |
| pass_idx | output | 1 | 0 for the first pass, 1 for the drain and second pass |
| octet_idx | output | BANK_LOG | Octet being read |
| rd_en | output | 1 | Read strobe for all banks |
| rd_rot | output | BANK_LOG | Lane-to-bank rotation for the crossbar |
| rd_addr | output | BANKS*BANK_LOG | Per-bank read word address, bank b at bits [3b+2:3b] |
| wr_en | output | 1 | Write strobe for all banks |
| wr_addr | output | BANKS*BANK_LOG | Per-bank write word address, same packing |

## Verification
The read outputs, `busy`, `pass_idx`, `octet_idx` and `done` follow from the state register, so they change one clock after the edge that samples `start`. The write outputs appear `PIPE_LAT` clocks after the read they mirror. The bench reference model advances on every rising edge. It keeps a `PIPE_LAT`-deep history of its own expected reads, and it compares all outputs at the following falling edge. The expected value therefore refers to the same cycle the design is in, and each write is checked against the read issued exactly `PIPE_LAT` cycles before. Per-pass visit tallies are checked in the `done` cycle, which is when the last write of a transform is issued.

// File: rtl/skew_agu_pkg.sv
package skew_agu_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN_A = 3'd1,
        ST_DRAIN = 3'd2,
        ST_RUN_B = 3'd3,
        ST_FLUSH = 3'd4
    } agu_state_t;

endpackage

// File: rtl/skew_agu_seq.sv
module skew_agu_seq
    import skew_agu_pkg::*;
#(
    parameter int BANK_LOG = 3,
    parameter int PIPE_LAT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    output logic                rd_en,
    output logic                pass_idx,
    output logic [BANK_LOG-1:0] octet_idx,
    output logic                busy,
    output logic                done
);
    localparam int WAIT_W = (PIPE_LAT < 2) ? 1 : $clog2(PIPE_LAT);
    localparam logic [BANK_LOG-1:0] OCT_MAX  = '1;
    localparam logic [WAIT_W-1:0]   WAIT_MAX = WAIT_W'(PIPE_LAT - 1);

    agu_state_t          state_q, state_d;
    logic [BANK_LOG-1:0] octet_q, octet_d;
    logic [WAIT_W-1:0]   wait_q, wait_d;
    logic                oct_last, wait_last;

    assign oct_last  = (octet_q == OCT_MAX);
    assign wait_last = (wait_q == WAIT_MAX);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            octet_q <= '0;
            wait_q  <= '0;
        end else begin
            state_q <= state_d;
            octet_q <= octet_d;
            wait_q  <= wait_d;
        end
    end

    // next state and counters
    always_comb begin
        state_d = state_q;
        octet_d = '0;
        wait_d  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_RUN_A;
            end
            ST_RUN_A: begin
                octet_d = octet_q + 1'b1;
                if (oct_last) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                wait_d = wait_q + 1'b1;
                if (wait_last) begin
                    state_d = ST_RUN_B;
                    wait_d  = '0;
                end
            end
            ST_RUN_B: begin
                octet_d = octet_q + 1'b1;
                if (oct_last) state_d = ST_FLUSH;
            end
            ST_FLUSH: begin
                wait_d = wait_q + 1'b1;
                if (wait_last) begin
                    state_d = ST_IDLE;
                    wait_d  = '0;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_en     = 1'b0;
        pass_idx  = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        octet_idx = octet_q;
        unique case (state_q)
            ST_IDLE: begin
                busy      = 1'b0;
                octet_idx = '0;
            end
            ST_RUN_A: rd_en = 1'b1;
            ST_DRAIN: begin
                pass_idx  = 1'b1;
                octet_idx = '0;
            end
            ST_RUN_B: begin
                rd_en    = 1'b1;
                pass_idx = 1'b1;
            end
            ST_FLUSH: begin
                pass_idx  = 1'b1;
                octet_idx = '0;
                done      = wait_last;
            end
            default: begin
                busy      = 1'b0;
                octet_idx = '0;
            end
        endcase
    end

endmodule

// File: rtl/skew_agu_map.sv
module skew_agu_map #(
    parameter int BANK_LOG = 3,
    parameter int BANKS    = 1 << BANK_LOG
) (
    input  logic                      rd_en,
    input  logic                      pass_idx,
    input  logic [BANK_LOG-1:0]       octet_idx,
    output logic [BANK_LOG-1:0]       rd_rot,
    output logic [BANKS*BANK_LOG-1:0] rd_addr
);
    assign rd_rot = rd_en ? octet_idx : '0;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        localparam logic [BANK_LOG-1:0] BIDX = BANK_LOG'(b);
        always_comb begin
            if (!rd_en)
                rd_addr[b*BANK_LOG +: BANK_LOG] = '0;
            else if (pass_idx)
                rd_addr[b*BANK_LOG +: BANK_LOG] = octet_idx;
            else
                rd_addr[b*BANK_LOG +: BANK_LOG] = BIDX - octet_idx;
        end
    end

endmodule

// File: rtl/skew_agu_delay.sv
module skew_agu_delay #(
    parameter int WIDTH = 25,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage[0] <= '0;
                else        stage[0] <= din;
            end
        end else begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage[i] <= '0;
                else        stage[i] <= stage[i-1];
            end
        end
    end

    assign dout = stage[DEPTH-1];

endmodule

// File: rtl/skew_bank_agu.sv
module skew_bank_agu #(
    parameter int BANK_LOG = 3,
    parameter int PIPE_LAT = 4,
    localparam int BANKS   = 1 << BANK_LOG,
    localparam int AW      = BANKS * BANK_LOG
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    output logic                busy,
    output logic                done,
    output logic                pass_idx,
    output logic [BANK_LOG-1:0] octet_idx,
    output logic                rd_en,
    output logic [BANK_LOG-1:0] rd_rot,
    output logic [AW-1:0]       rd_addr,
    output logic                wr_en,
    output logic [AW-1:0]       wr_addr
);
    logic [AW:0] wr_bundle;

    skew_agu_seq #(.BANK_LOG(BANK_LOG), .PIPE_LAT(PIPE_LAT)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rd_en     (rd_en),
        .pass_idx  (pass_idx),
        .octet_idx (octet_idx),
        .busy      (busy),
        .done      (done)
    );

    skew_agu_map #(.BANK_LOG(BANK_LOG), .BANKS(BANKS)) u_map (
        .rd_en     (rd_en),
        .pass_idx  (pass_idx),
        .octet_idx (octet_idx),
        .rd_rot    (rd_rot),
        .rd_addr   (rd_addr)
    );

    skew_agu_delay #(.WIDTH(AW + 1), .DEPTH(PIPE_LAT)) u_wdly (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({rd_en, rd_addr}),
        .dout  (wr_bundle)
    );

    assign wr_en   = wr_bundle[AW];
    assign wr_addr = wr_bundle[AW-1:0];

endmodule

// File: rtl/skew_bank_agu_chk.sv
module skew_bank_agu_chk #(
    parameter int BANK_LOG = 3,
    parameter int PIPE_LAT = 4,
    localparam int BANKS   = 1 << BANK_LOG,
    localparam int AW      = BANKS * BANK_LOG
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                busy,
    input logic                done,
    input logic                pass_idx,
    input logic [BANK_LOG-1:0] octet_idx,
    input logic                rd_en,
    input logic [BANK_LOG-1:0] rd_rot,
    input logic [AW-1:0]       rd_addr,
    input logic                wr_en,
    input logic [AW-1:0]       wr_addr
);
    function automatic logic same_word(input logic [AW-1:0] a, input logic [AW-1:0] b);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < BANKS; i++)
            if (a[i*BANK_LOG +: BANK_LOG] == b[i*BANK_LOG +: BANK_LOG]) hit = 1'b1;
        return hit;
    endfunction

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_en && !wr_en && !done));

    assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_octet_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && octet_idx != '0) |-> (octet_idx == $past(octet_idx) + 1'b1));

    assert_skew_bank0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !pass_idx) |-> (rd_addr[BANK_LOG-1:0] == BANK_LOG'(0) - rd_rot));

    assert_flat_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && pass_idx) |-> (rd_addr == {BANKS{rd_rot}}));

    assert_no_rw_clash_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |-> !same_word(rd_addr, wr_addr));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_done_in_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pass_idx && !rd_en && wr_en));

endmodule

bind skew_bank_agu skew_bank_agu_chk #(.BANK_LOG(BANK_LOG), .PIPE_LAT(PIPE_LAT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .pass_idx  (pass_idx),
    .octet_idx (octet_idx),
    .rd_en     (rd_en),
    .rd_rot    (rd_rot),
    .rd_addr   (rd_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr)
);

// File: tb/tb_skew_bank_agu.sv
module tb_skew_bank_agu;
    localparam int NB  = 8;
    localparam int LG  = 3;
    localparam int LAT = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          busy, done, pass_idx, rd_en, wr_en;
    logic [LG-1:0] octet_idx, rd_rot;
    logic [NB*LG-1:0] rd_addr, wr_addr;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    skew_bank_agu #(.BANK_LOG(LG), .PIPE_LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .pass_idx(pass_idx), .octet_idx(octet_idx), .rd_en(rd_en), .rd_rot(rd_rot),
        .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr)
    );

    always #5 clk = ~clk;

    // model: phase 0 idle, 1 pass one, 2 drain, 3 pass two, 4 flush
    int m_phase = 0;
    int m_cnt   = 0;
    int h_en   [LAT];
    int h_addr [LAT][NB];
    int vis    [2][NB*NB];

    function automatic int bank_of(int e);
        return ((e % NB) + (e / NB)) % NB;
    endfunction

    function automatic int sample_of(int phase, int cnt, int lane);
        if (phase == 1) return cnt + NB * lane;
        return NB * cnt + lane;
    endfunction

    function automatic int exp_addr(int phase, int cnt, int bank);
        if (phase == 1 || phase == 3)
            for (int k = 0; k < NB; k++)
                if (bank_of(sample_of(phase, cnt, k)) == bank)
                    return sample_of(phase, cnt, k) / NB;
        return 0;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0;
            m_cnt   = 0;
            for (int i = 0; i < LAT; i++) begin
                h_en[i] = 0;
                for (int b = 0; b < NB; b++) h_addr[i][b] = 0;
            end
        end else begin
            for (int i = LAT - 1; i > 0; i--) begin
                h_en[i] = h_en[i-1];
                for (int b = 0; b < NB; b++) h_addr[i][b] = h_addr[i-1][b];
            end
            h_en[0] = (m_phase == 1 || m_phase == 3) ? 1 : 0;
            for (int b = 0; b < NB; b++) h_addr[0][b] = exp_addr(m_phase, m_cnt, b);
            case (m_phase)
                0: if (start) begin m_phase = 1; m_cnt = 0; end
                1: if (m_cnt == NB - 1) begin m_phase = 2; m_cnt = 0; end else m_cnt++;
                2: if (m_cnt == LAT - 1) begin m_phase = 3; m_cnt = 0; end else m_cnt++;
                3: if (m_cnt == NB - 1) begin m_phase = 4; m_cnt = 0; end else m_cnt++;
                default: if (m_cnt == LAT - 1) begin m_phase = 0; m_cnt = 0; end else m_cnt++;
            endcase
        end
    end

    always @(negedge clk) begin
        int e_rd, e_pass, e_oct, e_done, a, e;
        bit used [NB*NB];
        if (!finished) begin
            if (!rst_n) begin
                for (int p = 0; p < 2; p++)
                    for (int i = 0; i < NB*NB; i++) vis[p][i] = 0;
            end
            e_rd   = (m_phase == 1 || m_phase == 3) ? 1 : 0;
            e_pass = (m_phase >= 2) ? 1 : 0;
            e_oct  = e_rd ? m_cnt : 0;
            e_done = (m_phase == 4 && m_cnt == LAT - 1) ? 1 : 0;
            if (m_phase == 0) begin
                chk(!busy && !rd_en && !wr_en && rd_addr == 0 && wr_addr == 0 && rd_rot == 0,
                    "R1", "idle outputs", int'(rd_addr), 0);
            end
            chk(busy == (m_phase != 0), "R10", "busy", busy, m_phase != 0);
            chk(rd_en == e_rd, (m_phase == 2) ? "R5" : "R2", "rd_en", rd_en, e_rd);
            chk(pass_idx == e_pass, "R10", "pass_idx", pass_idx, e_pass);
            chk(octet_idx == e_oct, "R10", "octet_idx", octet_idx, e_oct);
            chk(rd_rot == e_oct, (m_phase == 3) ? "R4" : "R3", "rd_rot", rd_rot, e_oct);
            chk(done == e_done, "R9", "done", done, e_done);
            for (int b = 0; b < NB; b++) begin
                a = int'(rd_addr[b*LG +: LG]);
                chk(a == exp_addr(m_phase, m_cnt, b), (m_phase == 3) ? "R4" : "R3",
                    $sformatf("rd_addr bank %0d", b), a, exp_addr(m_phase, m_cnt, b));
            end
            chk(wr_en == h_en[LAT-1], "R6", "wr_en", wr_en, h_en[LAT-1]);
            for (int b = 0; b < NB; b++) begin
                a = int'(wr_addr[b*LG +: LG]);
                chk(a == h_addr[LAT-1][b], "R6", $sformatf("wr_addr bank %0d", b), a, h_addr[LAT-1][b]);
            end
            if (rd_en && wr_en) begin
                for (int b = 0; b < NB; b++)
                    chk(rd_addr[b*LG +: LG] != wr_addr[b*LG +: LG], "R7",
                        $sformatf("rw clash bank %0d", b), int'(rd_addr[b*LG +: LG]),
                        int'(wr_addr[b*LG +: LG]));
            end
            if (rd_en && rst_n) begin
                for (int i = 0; i < NB*NB; i++) used[i] = 0;
                for (int b = 0; b < NB; b++) begin
                    a = int'(rd_addr[b*LG +: LG]);
                    e = NB * a + ((b - a + NB) % NB);
                    chk(!used[e], "R8", "sample twice in one cycle", e, -1);
                    used[e] = 1;
                    if (pass_idx) chk(e / NB == int'(octet_idx), "R8", "pass two octet row", e / NB, octet_idx);
                    else          chk(e % NB == int'(octet_idx), "R8", "pass one octet column", e % NB, octet_idx);
                    vis[pass_idx][e]++;
                end
            end
            if (done && rst_n) begin
                for (int p = 0; p < 2; p++)
                    for (int i = 0; i < NB*NB; i++) begin
                        chk(vis[p][i] == 1, "R8", $sformatf("visits pass %0d sample %0d", p, i), vis[p][i], 1);
                        vis[p][i] = 0;
                    end
            end
        end
    end

    task automatic idle_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); #2 start = 1'b1;
        @(negedge clk); #2 start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2 rst_n = 1'b1;
        idle_cycles(4);                      // R1 reset state
        pulse_start();                       // R2 R3 R4 R5 R6 single transform
        idle_cycles(30);
        @(negedge clk); #2 start = 1'b1;     // held start: back to back, ignored while busy (R2)
        idle_cycles(70);
        #2 start = 1'b0;
        idle_cycles(30);
        pulse_start();                       // stray start pulses during pass two
        idle_cycles(14);
        pulse_start();
        idle_cycles(30);
        pulse_start();                       // reset in the middle of pass one
        idle_cycles(4);
        #2 rst_n = 1'b0;
        idle_cycles(2);
        #2 rst_n = 1'b1;
        idle_cycles(4);
        pulse_start();
        idle_cycles(30);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule